// File: doc/BRIEF.md
# Receive Buffer Descriptor Prefetcher

This block walks a list of receive buffer descriptors held in host memory and hands one buffer address at a time to the receive data path. It reads the list through a word-read port that accepts one request at a time. The port has a request/grant phase and an in-order response phase. Each usable descriptor becomes a 64-bit buffer address on a valid/ready output. A second storage slot lets the next descriptor be fetched while the current buffer is still held downstream.

Two descriptor layouts are selectable. In the narrow layout one 32-bit word per entry carries the address together with two flag bits. In the wide layout two words per entry are used: the first holds the low address bits and the flags, and the second holds the high address bits. With prefetch mode off, software advances a producer index and the block consumes entries up to it, wrapping at a configured list length. With prefetch mode on, the flags in each entry control the walk. A set end flag sends the next fetch back to the list base. A clear valid flag stalls the walk on that entry, which is re-read after a programmable delay.

Top module: `rxdp_prefetch`

## Requirements
- R1: After reset `buf_valid` and `rd_req` are low.
- R2: In the narrow layout (`cfg_wide`=0), entry i is read from word address base+4*i. The entry is presented as `buf_addr` = {32'h0, word with bits [1:0] forced to 0}.
- R3: In the wide layout (`cfg_wide`=1), entry i is read as two words: first at base+8*i, then at base+8*i+4. The entry is presented as `buf_addr` = {second word, first word with bits [1:0] forced to 0}.
- R4: With `cfg_prefetch`=0, a fetch starts only while the entry index differs from `sw_prod_idx`. The index advances to 0 after entry `cfg_len`-1.
- R5: With `cfg_prefetch`=1, a used entry whose end flag (bit 1 of the first word) is 1 makes the next fetch read entry 0.
- R6: With `cfg_prefetch`=0, the end flag (bit 1) and the valid flag (bit 0) have no effect: every entry is delivered and the walk goes to the next index.
- R7: With `cfg_prefetch`=1, an entry whose valid flag (bit 0) is 0 is not delivered. The same entry is read again no earlier than `cfg_poll` cycles after its response.
- R8: While `buf_ready` stays low, at most two entries are fetched and held. No further read request is issued.
- R9: Once `buf_valid` is high, it stays high and `buf_addr` stays unchanged until `buf_ready` is seen high.
- R10: Entries are delivered in fetch order, including when a fetched entry is stored in the same cycle as one leaves.
- R11: `rd_req` with a given `rd_addr` stays asserted until `rd_gnt`. `rd_addr` is always word aligned, because the low two bits of `cfg_base` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | Allows new fetches to start |
| cfg_base | input | 32 | Byte address of list entry 0 |
| cfg_wide | input | 1 | 1 selects the two-word layout |
| cfg_prefetch | input | 1 | 1 lets the flags drive the walk |
| cfg_len | input | IDX_W | List length in entries (0 means 2^IDX_W) |
| cfg_poll | input | POLL_W | Re-read delay for an unusable entry |
| sw_prod_idx | input | IDX_W | Producer index written by software |
| rd_req | output | 1 | Read request |
| rd_addr | output | 32 | Read byte address |
| rd_gnt | input | 1 | Request accepted |
| rd_rvalid | input | 1 | Read response present |
| rd_rdata | input | 32 | Read response word |
| buf_valid | output | 1 | Buffer address available |
| buf_ready | input | 1 | Receive path takes the address |
| buf_addr | output | 64 | Buffer address |

## Verification
The collision that matters is a fetched entry being stored into the holding stage in the same cycle that the output entry is taken. If this is mishandled, an address is dropped or delivered twice. The bench provokes it by fetching with `buf_ready` low until both slots fill. It then pulses `buf_ready` sparsely, so that frees and fresh completions keep landing together. The delivered sequence must then be exactly the consecutive list entries in order, with no gap and no repeat.

// File: rtl/rxdp_pkg.sv
package rxdp_pkg;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned BUF_W     = 64;
   localparam int unsigned VLD_BIT   = 0;
   localparam int unsigned END_BIT   = 1;
   localparam int unsigned FLAG_BITS = 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ_LO,
      ST_WAIT_LO,
      ST_REQ_HI,
      ST_WAIT_HI,
      ST_POLL
   } fetch_st_e;
endpackage

// File: rtl/rxdp_addr_gen.sv
module rxdp_addr_gen #(
   parameter int unsigned IDX_W = 8
) (
   input  logic [31:0]      base,
   input  logic [IDX_W-1:0] idx,
   input  logic             wide,
   input  logic             second,
   output logic [31:0]      addr
);
   localparam int unsigned NARROW_SH = 2;
   localparam int unsigned WIDE_SH   = 3;

   logic [31:0] base_al;
   logic [31:0] ent_off;

   always_comb begin
      base_al = {base[31:2], 2'b00};
      ent_off = wide ? (32'(idx) << WIDE_SH) : (32'(idx) << NARROW_SH);
      addr    = base_al + ent_off + (second ? 32'd4 : 32'd0);
   end
endmodule

// File: rtl/rxdp_ring_ptr.sv
module rxdp_ring_ptr #(
   parameter int unsigned IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             force_wrap,
   input  logic [IDX_W-1:0] len,
   output logic [IDX_W-1:0] idx
);
   logic [IDX_W-1:0] inc;

   assign inc = idx + IDX_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (adv) begin
         if (force_wrap || inc == len) idx <= '0;
         else                          idx <= inc;
      end
   end
endmodule

// File: rtl/rxdp_poll_tmr.sv
module rxdp_poll_tmr #(
   parameter int unsigned POLL_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [POLL_W-1:0] delay,
   output logic              done
);
   logic [POLL_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= delay;
      else if (cnt != '0)    cnt <= cnt - POLL_W'(1);
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/rxdp_hold.sv
module rxdp_hold #(
   parameter int unsigned DW       = 64,
   parameter bit          USE_HOLD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   output logic          full,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [DW-1:0] out_data
);
   generate
      if (USE_HOLD) begin : g_two
         logic          o_v, h_v;
         logic [DW-1:0] o_d, h_d;
         logic          pop;

         assign pop = o_v && out_ready;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               o_v <= 1'b0;
               h_v <= 1'b0;
               o_d <= '0;
               h_d <= '0;
            end else if (pop) begin
               if (h_v) begin
                  o_d <= h_d;
                  h_v <= push;
                  if (push) h_d <= push_data;
               end else begin
                  o_v <= push;
                  if (push) o_d <= push_data;
               end
            end else if (push) begin
               if (!o_v) begin
                  o_v <= 1'b1;
                  o_d <= push_data;
               end else begin
                  h_v <= 1'b1;
                  h_d <= push_data;
               end
            end
         end

         assign full      = o_v && h_v;
         assign out_valid = o_v;
         assign out_data  = o_d;
      end else begin : g_one
         logic          o_v;
         logic [DW-1:0] o_d;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               o_v <= 1'b0;
               o_d <= '0;
            end else if (push) begin
               o_v <= 1'b1;
               o_d <= push_data;
            end else if (out_ready) begin
               o_v <= 1'b0;
            end
         end

         assign full      = o_v;
         assign out_valid = o_v;
         assign out_data  = o_d;
      end
   endgenerate
endmodule

// File: rtl/rxdp_prefetch.sv
module rxdp_prefetch
   import rxdp_pkg::*;
#(
   parameter int unsigned IDX_W    = 8,
   parameter int unsigned POLL_W   = 8,
   parameter bit          USE_HOLD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [31:0]       cfg_base,
   input  logic              cfg_wide,
   input  logic              cfg_prefetch,
   input  logic [IDX_W-1:0]  cfg_len,
   input  logic [POLL_W-1:0] cfg_poll,
   input  logic [IDX_W-1:0]  sw_prod_idx,
   output logic              rd_req,
   output logic [31:0]       rd_addr,
   input  logic              rd_gnt,
   input  logic              rd_rvalid,
   input  logic [31:0]       rd_rdata,
   output logic              buf_valid,
   input  logic              buf_ready,
   output logic [63:0]       buf_addr
);
   localparam logic [WORD_W-1:0] FLAG_MASK = ~WORD_W'((1 << FLAG_BITS) - 1);

   generate
      if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx
         $error("rxdp_prefetch: IDX_W must be 1..16");
      end
      if (POLL_W < 1 || POLL_W > 24) begin : g_bad_poll
         $error("rxdp_prefetch: POLL_W must be 1..24");
      end
   endgenerate

   fetch_st_e         st, st_nx;
   logic [WORD_W-1:0] lo_q;
   logic [IDX_W-1:0]  idx;
   logic              full;
   logic              tmr_done;

   logic              cmp;
   logic [WORD_W-1:0] cmp_lo;
   logic [WORD_W-1:0] cmp_hi;
   logic              usable;
   logic              push;
   logic              poll_load;
   logic              start;
   logic [BUF_W-1:0]  push_data;

   always_comb begin
      start  = (st == ST_IDLE) && run && !full &&
               (cfg_prefetch || (idx != sw_prod_idx));
      cmp    = rd_rvalid && (((st == ST_WAIT_LO) && !cfg_wide) || (st == ST_WAIT_HI));
      cmp_lo = (st == ST_WAIT_LO) ? rd_rdata : lo_q;
      cmp_hi = (st == ST_WAIT_HI) ? rd_rdata : '0;
      usable = !cfg_prefetch || cmp_lo[VLD_BIT];
      push      = cmp && usable;
      poll_load = cmp && !usable;
      push_data = {cmp_hi, cmp_lo & FLAG_MASK};
   end

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:    if (start) st_nx = ST_REQ_LO;
         ST_REQ_LO:  if (rd_gnt) st_nx = ST_WAIT_LO;
         ST_WAIT_LO: if (rd_rvalid) begin
                        if (cfg_wide)    st_nx = ST_REQ_HI;
                        else if (usable) st_nx = ST_IDLE;
                        else             st_nx = ST_POLL;
                     end
         ST_REQ_HI:  if (rd_gnt) st_nx = ST_WAIT_HI;
         ST_WAIT_HI: if (rd_rvalid) st_nx = usable ? ST_IDLE : ST_POLL;
         ST_POLL:    if (tmr_done) st_nx = ST_IDLE;
         default:    st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         lo_q <= '0;
      end else begin
         st <= st_nx;
         if (st == ST_WAIT_LO && rd_rvalid) lo_q <= rd_rdata;
      end
   end

   assign rd_req = (st == ST_REQ_LO) || (st == ST_REQ_HI);

   rxdp_addr_gen #(.IDX_W(IDX_W)) u_addr (
      .base   (cfg_base),
      .idx    (idx),
      .wide   (cfg_wide),
      .second (st == ST_REQ_HI),
      .addr   (rd_addr)
   );

   rxdp_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (push),
      .force_wrap (cfg_prefetch && cmp_lo[END_BIT]),
      .len        (cfg_len),
      .idx        (idx)
   );

   rxdp_poll_tmr #(.POLL_W(POLL_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (poll_load),
      .delay (cfg_poll),
      .done  (tmr_done)
   );

   rxdp_hold #(.DW(BUF_W), .USE_HOLD(USE_HOLD)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (push_data),
      .full      (full),
      .out_valid (buf_valid),
      .out_ready (buf_ready),
      .out_data  (buf_addr)
   );
endmodule

// File: rtl/rxdp_chk.sv
module rxdp_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        rd_req,
   input logic [31:0] rd_addr,
   input logic        rd_gnt,
   input logic        buf_valid,
   input logic        buf_ready,
   input logic [63:0] buf_addr
);
   // R9
   a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      buf_valid && !buf_ready |=> buf_valid && $stable(buf_addr));

   // R11
   a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !rd_gnt |=> rd_req && $stable(rd_addr));

   // R11
   a_r11_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> rd_addr[1:0] == 2'b00);

   // R2 and R3: flag bits never reach the buffer address
   a_r2_flags_masked: assert property (@(posedge clk) disable iff (!rst_n)
      buf_valid |-> buf_addr[1:0] == 2'b00);
endmodule

bind rxdp_prefetch rxdp_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_req    (rd_req),
   .rd_addr   (rd_addr),
   .rd_gnt    (rd_gnt),
   .buf_valid (buf_valid),
   .buf_ready (buf_ready),
   .buf_addr  (buf_addr)
);

// File: tb/rxdp_prefetch_tb.sv
module rxdp_prefetch_tb;
   localparam logic [31:0] BASE = 32'h0000_4000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic [31:0] cfg_base = BASE;
   logic        cfg_wide = 1'b0;
   logic        cfg_prefetch = 1'b0;
   logic [7:0]  cfg_len = 8'd8;
   logic [7:0]  cfg_poll = 8'd0;
   logic [7:0]  sw_prod_idx = 8'd0;
   logic        rd_req;
   logic [31:0] rd_addr;
   logic        rd_gnt = 1'b0;
   logic        rd_rvalid = 1'b0;
   logic [31:0] rd_rdata = '0;
   logic        buf_valid;
   logic        buf_ready = 1'b0;
   logic [63:0] buf_addr;

   always #10 clk = ~clk;

   rxdp_prefetch u_dut (.*);

   logic [31:0] mem [0:63];
   int          cyc = 0;
   int          n_req = 0, n_rsp = 0, n_got = 0;
   logic [31:0] req_addr [0:1023];
   int          req_cyc  [0:1023];
   int          rsp_cyc  [0:1023];
   logic [63:0] got      [0:1023];
   logic        pend = 1'b0;
   logic [31:0] pend_addr = '0;
   int          lat = 0;
   int          vectors = 0, miscompares = 0;

   function automatic logic [31:0] rd_mem(input logic [31:0] a);
      return mem[((a - BASE) >> 2) & 63];
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         pend <= 1'b0;
      end else begin
         if (rd_req && rd_gnt) begin
            req_addr[n_req & 1023] <= rd_addr;
            req_cyc[n_req & 1023]  <= cyc;
            n_req     <= n_req + 1;
            pend      <= 1'b1;
            pend_addr <= rd_addr;
            lat       <= 2;
         end else if (rd_rvalid) begin
            pend <= 1'b0;
         end else if (pend && lat != 0) begin
            lat <= lat - 1;
         end
         if (rd_rvalid) begin
            rsp_cyc[n_rsp & 1023] <= cyc;
            n_rsp <= n_rsp + 1;
         end
         if (buf_valid && buf_ready) begin
            got[n_got & 1023] <= buf_addr;
            n_got <= n_got + 1;
         end
      end
   end

   always @(negedge clk) begin
      rd_gnt    <= (cyc % 3) != 0;
      rd_rvalid <= pend && lat == 0 && !rd_rvalid;
      rd_rdata  <= rd_mem(pend_addr);
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; run = 1'b0; buf_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wait_got(input int target);
      int t = 0;
      while (n_got < target && t < 2000) begin
         @(negedge clk);
         t++;
      end
   endtask

   task automatic t_reset();
      do_reset();
      chk(buf_valid == 1'b0, "R1 buf_valid after reset", 64'(buf_valid), 64'd0);
      chk(rd_req == 1'b0, "R1 rd_req after reset", 64'(rd_req), 64'd0);
   endtask

   // R2 R4 R6
   task automatic t_narrow();
      int q0, g0;
      do_reset();
      for (int i = 0; i < 64; i++) mem[i] = 32'hA0B0_0000 + 32'(i) * 32'h100 + 32'(i & 3);
      cfg_base = BASE; cfg_wide = 1'b0; cfg_prefetch = 1'b0; cfg_len = 8'd4; sw_prod_idx = 8'd0;
      q0 = n_req; g0 = n_got;
      run = 1'b1; buf_ready = 1'b1;
      repeat (30) @(negedge clk);
      chk(n_req == q0, "R4 no fetch when index equals producer", 64'(n_req - q0), 64'd0);
      sw_prod_idx = 8'd3;
      wait_got(g0 + 3);
      repeat (30) @(negedge clk);
      chk(n_req - q0 == 3, "R4 stops at producer index", 64'(n_req - q0), 64'd3);
      for (int i = 0; i < 3; i++) begin
         chk(got[g0 + i] == {32'h0, mem[i] & 32'hFFFF_FFFC}, "R2 R6 narrow entry", got[g0 + i],
             {32'h0, mem[i] & 32'hFFFF_FFFC});
         chk(req_addr[q0 + i] == BASE + 32'(4 * i), "R2 narrow read address", 64'(req_addr[q0 + i]),
             64'(BASE + 32'(4 * i)));
      end
      sw_prod_idx = 8'd1;
      wait_got(g0 + 5);
      chk(got[g0 + 3] == {32'h0, mem[3] & 32'hFFFF_FFFC}, "R6 end flag ignored", got[g0 + 3],
          {32'h0, mem[3] & 32'hFFFF_FFFC});
      chk(got[g0 + 4] == {32'h0, mem[0] & 32'hFFFF_FFFC}, "R4 wrap at list length", got[g0 + 4],
          {32'h0, mem[0] & 32'hFFFF_FFFC});
      run = 1'b0;
   endtask

   // R3 R5 R11
   task automatic t_wide();
      int q0, g0;
      logic [63:0] exp;
      do_reset();
      for (int i = 0; i < 32; i++) begin
         mem[2 * i]     = 32'hC000_0001 + (32'(i) << 8) + ((i == 2) ? 32'd2 : 32'd0);
         mem[2 * i + 1] = 32'h0000_0010 + 32'(i);
      end
      cfg_base = BASE + 32'd2; cfg_wide = 1'b1; cfg_prefetch = 1'b1; cfg_len = 8'd8;
      q0 = n_req; g0 = n_got;
      run = 1'b1; buf_ready = 1'b1;
      wait_got(g0 + 6);
      run = 1'b0;
      chk(req_addr[q0] == BASE, "R11 base low bits ignored", 64'(req_addr[q0]), 64'(BASE));
      chk(req_addr[q0 + 3] == BASE + 32'd12, "R3 second word address", 64'(req_addr[q0 + 3]),
          64'(BASE + 32'd12));
      for (int k = 0; k < 6; k++) begin
         int e = k % 3;
         exp = {mem[2 * e + 1], mem[2 * e] & 32'hFFFF_FFFC};
         chk(got[g0 + k] == exp, "R3 R5 wide entry with end wrap", got[g0 + k], exp);
      end
   endtask

   // R7
   task automatic t_poll();
      int q0, r0, g0, t;
      do_reset();
      for (int i = 0; i < 64; i++) mem[i] = 32'h7000_0001 + (32'(i) << 4);
      mem[0] = 32'h1234_5670;
      cfg_base = BASE; cfg_wide = 1'b0; cfg_prefetch = 1'b1; cfg_len = 8'd8; cfg_poll = 8'd12;
      q0 = n_req; r0 = n_rsp; g0 = n_got;
      run = 1'b1; buf_ready = 1'b1;
      t = 0;
      while (n_req < q0 + 2 && t < 500) begin @(negedge clk); t++; end
      chk(n_req >= q0 + 2, "R7 re-read issued", 64'(n_req - q0), 64'd2);
      chk(req_addr[q0 + 1] == BASE, "R7 re-read same entry", 64'(req_addr[q0 + 1]), 64'(BASE));
      chk(req_cyc[q0 + 1] - rsp_cyc[r0] >= 12, "R7 poll delay respected",
          64'(req_cyc[q0 + 1] - rsp_cyc[r0]), 64'd12);
      chk(n_got == g0, "R7 invalid entry not delivered", 64'(n_got - g0), 64'd0);
      mem[0] = 32'h1234_5671;
      wait_got(g0 + 1);
      run = 1'b0;
      chk(got[g0] == 64'h0000_0000_1234_5670, "R7 delivered once valid", got[g0],
          64'h0000_0000_1234_5670);
      cfg_poll = 8'd0;
   endtask

   // R8 R9 R10
   task automatic t_hold();
      int q0, g0, t;
      do_reset();
      for (int i = 0; i < 64; i++) mem[i] = 32'h5000_0001 + (32'(i) << 4);
      cfg_base = BASE; cfg_wide = 1'b0; cfg_prefetch = 1'b1; cfg_len = 8'd16;
      q0 = n_req; g0 = n_got;
      run = 1'b1; buf_ready = 1'b0;
      repeat (60) @(negedge clk);
      chk(n_req - q0 == 2, "R8 two entries held", 64'(n_req - q0), 64'd2);
      chk(buf_valid == 1'b1, "R9 valid held", 64'(buf_valid), 64'd1);
      chk(buf_addr == {32'h0, mem[0] & 32'hFFFF_FFFC}, "R9 address held", buf_addr,
          {32'h0, mem[0] & 32'hFFFF_FFFC});
      t = 0;
      while (n_got < g0 + 8 && t < 3000) begin
         buf_ready = (cyc % 4) == 0;
         @(negedge clk);
         t++;
      end
      run = 1'b0; buf_ready = 1'b0;
      for (int k = 0; k < 8; k++)
         chk(got[g0 + k] == {32'h0, mem[k] & 32'hFFFF_FFFC}, "R10 in-order delivery", got[g0 + k],
             {32'h0, mem[k] & 32'hFFFF_FFFC});
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_narrow();
            t_wide();
            t_poll();
            t_hold();
         end
         begin
            repeat (150000) @(posedge clk);
            vectors++; miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule